// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block is the column side of a two-bank, 16-bit synchronous DRAM. It receives already decoded commands (read, write, burst stop, precharge) together with a bank and a start column. For each beat of a burst it drives one column access on an internal array port. Write data is taken from the data bus in the same cycle as the access. Read data returns from the array one cycle after the access and leaves the block after the configured CAS latency. Each byte lane of the read data has its own output enable, which is what a pad ring needs to drive a tri-state bus.

Bursts may be 1, 2, 4 or 8 beats, which wrap inside their aligned block and end on their own. A burst may also be full page: it walks the 256-column row, wraps back past its start, and keeps going until a burst stop arrives. The two byte masks act in two ways. On reads they gate the lane output enables two cycles later, and they do not pause the internal column sequence. On writes they gate the byte strobes in the same cycle.

After a burst stop, the block watches for a precharge to the stopped bank. It raises a one-cycle error pulse if the precharge is later than a set number of cycles.

Top module: `sdram_col_burst`

## Requirements
- R1: After reset, and until a command arrives, `arr_en`, `dq_oe` and `pre_late` are all low.
- R2: Commands use `cmd_op` = 01 for read, 10 for write, 11 for burst stop and 00 for precharge, qualified by `cmd_valid`. `cfg_bl` sets the burst length: 000 → 1, 001 → 2, 010 → 4, 011 → 8, 111 → full page. For a burst of length L issued at cycle T with start column s, beat k goes out in cycle T+k at column (s with its low log2(L) bits cleared) plus ((s+k) mod L). After L beats the array port goes idle.
- R3: In full-page mode, beat k uses column (s+k) mod 256. The burst keeps issuing beats past beat 255 with no end of its own.
- R4: In the cycle of a burst stop, and in every later cycle until a new read or write, no array access is issued. Read beats issued before the stop still appear on the bus.
- R5: `cfg_cl` = 0 selects CAS latency 2 and 1 selects 3. The read data of beat k of a read issued in cycle T appears on `dq_out` in cycle T+CL+k.
- R6: A read lane that carries data is enabled unless its mask was high two cycles earlier. `dqm_hi` gates `dq_oe[1]` (bits 15:8) and `dqm_lo` gates `dq_oe[0]` (bits 7:0), each lane on its own. The delay does not depend on CAS latency.
- R7: Masked read beats still advance the column. The first unmasked beat after a mask carries the data of its own column.
- R8: During a write beat, `arr_wstrb[1]` is the inverse of `dqm_hi` and `arr_wstrb[0]` is the inverse of `dqm_lo` in the same cycle. `arr_wdata` equals `dq_in`.
- R9: A read or write that arrives during a burst ends that burst. Its first beat goes out in the same cycle at its own start column.
- R10: If a burst stop to bank b occurs in cycle T and no precharge to b occurs in cycles T+1 through T+PRE_LIMIT, `pre_late` is high for exactly cycle T+PRE_LIMIT+1. A precharge inside that window clears the watch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_bank | input | 1 | Target bank |
| cmd_col | input | COL_W | Start column of a read or write |
| cfg_bl | input | 3 | Burst length select |
| cfg_cl | input | 1 | CAS latency select (0: 2, 1: 3) |
| dqm_hi | input | 1 | Upper byte mask |
| dqm_lo | input | 1 | Lower byte mask |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 2 | Per-lane output enable (1 = upper byte) |
| arr_en | output | 1 | Array access this cycle |
| arr_we | output | 1 | Access is a write |
| arr_bank | output | 1 | Array bank |
| arr_col | output | COL_W | Array column |
| arr_wdata | output | DATA_W | Array write data |
| arr_wstrb | output | 2 | Array byte write strobes |
| arr_rdata | input | DATA_W | Array read data, valid the cycle after a read access |
| pre_late | output | 1 | One-cycle pulse: precharge missed its window |

## Verification
Array accesses are combinational within the beat's own cycle, so the bench checks the column, the direction and the strobes immediately after it drives each beat. Read data is due CL cycles after its beat: the bench files each expected word under that future cycle number and compares `dq_out` and `dq_oe` in that cycle. The lane enables are compared against the mask values the bench drove two cycles before. The precharge watch is modelled as a due cycle, T+PRE_LIMIT+1, that a matching precharge cancels, and `pre_late` is compared against it in every cycle.

// File: rtl/sdcb_pkg.sv
`timescale 1ns/1ps
package sdcb_pkg;

    typedef enum logic [1:0] {
        OP_PRECHARGE = 2'b00,
        OP_READ      = 2'b01,
        OP_WRITE     = 2'b10,
        OP_STOP      = 2'b11
    } sdcb_op_e;

    localparam logic [2:0] BL_FULL_PAGE = 3'b111;

    // log2 of the fixed burst length; full page is handled separately
    function automatic int burst_log2(input logic [2:0] sel);
        case (sel)
            3'b001:  return 1;
            3'b010:  return 2;
            3'b011:  return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic is_access(input logic v, input logic [1:0] op);
        return v && (op == OP_READ || op == OP_WRITE);
    endfunction

endpackage

// File: rtl/sdcb_burst_seq.sv
`timescale 1ns/1ps
module sdcb_burst_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bank,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       cfg_bl,
    output logic             iss_en,
    output logic             iss_we,
    output logic             iss_bank,
    output logic [COL_W-1:0] iss_col
);
    import sdcb_pkg::*;

    typedef struct packed {
        logic             active;
        logic             write;
        logic             bank;
        logic             full;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] wrap_mask;
    } bstate_t;

    bstate_t          st_q;
    logic             start_cmd;
    logic             stop_cmd;
    logic             last_beat;
    logic [COL_W-1:0] new_mask;
    logic [COL_W-1:0] seq_col;

    assign start_cmd = is_access(cmd_valid, cmd_op);
    assign stop_cmd  = cmd_valid && (cmd_op == OP_STOP);

    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            new_mask[i] = (cfg_bl == BL_FULL_PAGE) || (i < burst_log2(cfg_bl));
        end
    end

    assign seq_col   = (st_q.start & ~st_q.wrap_mask)
                     | ((st_q.start + st_q.beat) & st_q.wrap_mask);
    assign last_beat = !st_q.full && (st_q.beat == st_q.wrap_mask);

    always_comb begin
        iss_en   = 1'b0;
        iss_we   = 1'b0;
        iss_bank = st_q.bank;
        iss_col  = seq_col;
        if (start_cmd) begin
            iss_en   = 1'b1;
            iss_we   = (cmd_op == OP_WRITE);
            iss_bank = cmd_bank;
            iss_col  = cmd_col;
        end else if (!stop_cmd && st_q.active) begin
            iss_en = 1'b1;
            iss_we = st_q.write;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (start_cmd) begin
            st_q.active    <= (cfg_bl == BL_FULL_PAGE) || (new_mask != '0);
            st_q.write     <= (cmd_op == OP_WRITE);
            st_q.bank      <= cmd_bank;
            st_q.full      <= (cfg_bl == BL_FULL_PAGE);
            st_q.start     <= cmd_col;
            st_q.beat      <= COL_W'(1);
            st_q.wrap_mask <= new_mask;
        end else if (stop_cmd) begin
            st_q.active <= 1'b0;
        end else if (st_q.active) begin
            st_q.beat <= st_q.beat + 1'b1;
            if (last_beat) begin
                st_q.active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcb_read_pipe.sv
`timescale 1ns/1ps
module sdcb_read_pipe #(
    parameter int DATA_W  = 16,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_rd,
    input  logic              cfg_cl,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // vld[j] / dat[j]: beat issued j cycles ago; array data arrives at j = 1
    logic              vld [1:MAX_LAT];
    logic [DATA_W-1:0] dat [1:MAX_LAT];

    assign dat[1] = arr_rdata;

    always_ff @(posedge clk) begin
        if (rst) vld[1] <= 1'b0;
        else     vld[1] <= iss_rd;
    end

    for (genvar j = 2; j <= MAX_LAT; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) vld[j] <= 1'b0;
            else     vld[j] <= vld[j-1];
            dat[j] <= dat[j-1];
        end
    end

    assign rd_valid = cfg_cl ? vld[MAX_LAT] : vld[MAX_LAT-1];
    assign rd_data  = cfg_cl ? dat[MAX_LAT] : dat[MAX_LAT-1];

endmodule

// File: rtl/sdcb_lane_mask.sv
`timescale 1ns/1ps
module sdcb_lane_mask #(
    parameter int LANES = 2,
    parameter int DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] mask_d
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DELAY-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[DELAY-2:0], dqm[l]};
        end
        assign mask_d[l] = sh[DELAY-1];
    end

endmodule

// File: rtl/sdcb_pre_watch.sv
`timescale 1ns/1ps
module sdcb_pre_watch #(
    parameter int PRE_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bank,
    output logic       late
);
    import sdcb_pkg::*;

    localparam int CNT_W = $clog2(PRE_LIMIT + 1);

    logic             armed;
    logic             watch_bank;
    logic [CNT_W-1:0] elapsed;
    logic             pre_hit;

    assign pre_hit = cmd_valid && (cmd_op == OP_PRECHARGE) && (cmd_bank == watch_bank);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            watch_bank <= 1'b0;
            elapsed    <= '0;
            late       <= 1'b0;
        end else begin
            late <= 1'b0;
            if (cmd_valid && cmd_op == OP_STOP) begin
                armed      <= 1'b1;
                watch_bank <= cmd_bank;
                elapsed    <= CNT_W'(1);
            end else if (armed) begin
                if (pre_hit) begin
                    armed <= 1'b0;
                end else if (elapsed == CNT_W'(PRE_LIMIT)) begin
                    armed <= 1'b0;
                    late  <= 1'b1;
                end else begin
                    elapsed <= elapsed + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdram_col_burst.sv
`timescale 1ns/1ps
module sdram_col_burst #(
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int MAX_LAT   = 3,
    parameter int MASK_LAT  = 2,
    parameter int PRE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [2:0]        cfg_bl,
    input  logic              cfg_cl,
    input  logic              dqm_hi,
    input  logic              dqm_lo,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [1:0]        dq_oe,
    output logic              arr_en,
    output logic              arr_we,
    output logic              arr_bank,
    output logic [COL_W-1:0]  arr_col,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [1:0]        arr_wstrb,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              pre_late
);
    localparam int LANES = 2;

    logic             rd_valid;
    logic [LANES-1:0] mask_d;
    logic [LANES-1:0] dqm;

    assign dqm = {dqm_hi, dqm_lo};

    sdcb_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .cfg_bl    (cfg_bl),
        .iss_en    (arr_en),
        .iss_we    (arr_we),
        .iss_bank  (arr_bank),
        .iss_col   (arr_col)
    );

    sdcb_read_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_rpipe (
        .clk       (clk),
        .rst       (rst),
        .iss_rd    (arr_en && !arr_we),
        .cfg_cl    (cfg_cl),
        .arr_rdata (arr_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (dq_out)
    );

    sdcb_lane_mask #(.LANES(LANES), .DELAY(MASK_LAT)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .dqm    (dqm),
        .mask_d (mask_d)
    );

    sdcb_pre_watch #(.PRE_LIMIT(PRE_LIMIT)) u_watch (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .late      (pre_late)
    );

    assign dq_oe     = {LANES{rd_valid}} & ~mask_d;
    assign arr_wdata = dq_in;
    assign arr_wstrb = (arr_en && arr_we) ? ~dqm : '0;

endmodule

// File: rtl/sdcb_checker.sv
`timescale 1ns/1ps
module sdcb_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       dqm_hi,
    input logic       dqm_lo,
    input logic [1:0] dq_oe,
    input logic       arr_en,
    input logic       arr_we,
    input logic [1:0] arr_wstrb,
    input logic       pre_late
);
    logic stop_now;
    logic start_now;
    assign stop_now  = cmd_valid && (cmd_op == 2'b11);
    assign start_now = cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10);

    // R2: a beat that is not a fresh command continues a burst from the previous cycle
    a_r2_contiguous: assert property (@(posedge clk) disable iff (rst)
        (arr_en && !start_now) |-> $past(arr_en));

    // R4: nothing reaches the array in the stop cycle
    a_r4_stop_cycle: assert property (@(posedge clk) disable iff (rst)
        stop_now |-> !arr_en);

    // R4: the cycle after a stop stays idle unless a new command starts
    a_r4_after_stop: assert property (@(posedge clk) disable iff (rst)
        stop_now |=> (!arr_en || start_now));

    // R6: upper lane off two cycles after its mask
    a_r6_hi_lane: assert property (@(posedge clk) disable iff (rst)
        $past(dqm_hi, 2) |-> !dq_oe[1]);

    // R6: lower lane off two cycles after its mask
    a_r6_lo_lane: assert property (@(posedge clk) disable iff (rst)
        $past(dqm_lo, 2) |-> !dq_oe[0]);

    // R8: masked write lanes carry no strobe
    a_r8_hi_strobe: assert property (@(posedge clk) disable iff (rst)
        dqm_hi |-> !arr_wstrb[1]);

    a_r8_lo_strobe: assert property (@(posedge clk) disable iff (rst)
        dqm_lo |-> !arr_wstrb[0]);

    // R8: strobes only during write accesses
    a_r8_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
        (arr_wstrb != 2'b00) |-> (arr_en && arr_we));

    // R10: the late flag is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pre_late |=> !pre_late);

endmodule

bind sdram_col_burst sdcb_checker u_chk (.*);

// File: tb/sdram_col_burst_tb.sv
`timescale 1ns/1ps
module sdram_col_burst_tb;

    localparam int PRE = 16;
    localparam int HN  = 4096;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic        cmd_bank;
    logic [7:0]  cmd_col;
    logic [2:0]  cfg_bl;
    logic        cfg_cl;
    logic        dqm_hi;
    logic        dqm_lo;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        arr_en;
    logic        arr_we;
    logic        arr_bank;
    logic [7:0]  arr_col;
    logic [15:0] arr_wdata;
    logic [1:0]  arr_wstrb;
    logic [15:0] arr_rdata;
    logic        pre_late;

    always #2.5 clk = ~clk;

    sdram_col_burst #(.PRE_LIMIT(PRE)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
        .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .arr_en(arr_en), .arr_we(arr_we), .arr_bank(arr_bank),
        .arr_col(arr_col), .arr_wdata(arr_wdata), .arr_wstrb(arr_wstrb),
        .arr_rdata(arr_rdata), .pre_late(pre_late)
    );

    // array model: synchronous, read data one cycle after the access
    logic [15:0] mem [0:511];
    always @(posedge clk) begin
        if (arr_en) begin
            if (arr_we) begin
                if (arr_wstrb[0]) mem[{arr_bank, arr_col}][7:0]  <= arr_wdata[7:0];
                if (arr_wstrb[1]) mem[{arr_bank, arr_col}][15:8] <= arr_wdata[15:8];
            end else begin
                arr_rdata <= mem[{arr_bank, arr_col}];
            end
        end
    end

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    int    cur   = 0;
    int    pend_at = -1;
    logic  pend_bank = 1'b0;
    logic  ev [0:HN-1];
    logic [15:0] ed [0:HN-1];
    logic  hh [0:HN-1];
    logic  hl [0:HN-1];
    logic  mh [0:31];
    logic  ml [0:31];
    logic [2:0] g_bl = 3'b000;
    logic  g_cl = 1'b0;
    string data_req = "R5";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cur, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic b, input logic [7:0] c);
        return {c ^ (b ? 8'hA5 : 8'h3C), ~c};
    endfunction

    task automatic step(input logic v, input logic [1:0] op, input logic b,
                        input logic [7:0] c, input logic dh, input logic dl,
                        input logic [15:0] d);
        int   idx;
        logic h2;
        logic l2;
        logic [1:0] exp_oe;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_bank = b; cmd_col = c;
        dqm_hi = dh; dqm_lo = dl; dq_in = d; cfg_bl = g_bl; cfg_cl = g_cl;
        #1;
        cur = cyc;
        idx = cyc % HN;
        h2 = (cyc >= 2) ? hh[(cyc-2) % HN] : 1'b0;
        l2 = (cyc >= 2) ? hl[(cyc-2) % HN] : 1'b0;
        exp_oe = {ev[idx] & ~h2, ev[idx] & ~l2};
        chk(dq_oe == exp_oe, "R6", "dq_oe (R5 timing)", dq_oe, exp_oe);
        if (exp_oe[1]) chk(dq_out[15:8] == ed[idx][15:8], data_req, "dq_out[15:8]",
                           dq_out[15:8], ed[idx][15:8]);
        if (exp_oe[0]) chk(dq_out[7:0] == ed[idx][7:0], data_req, "dq_out[7:0]",
                           dq_out[7:0], ed[idx][7:0]);
        chk(pre_late == (cyc == pend_at), "R10", "pre_late", pre_late, cyc == pend_at);
        if (pend_at >= 0 && cyc >= pend_at) pend_at = -1;
        if (v && op == 2'b11) begin pend_at = cyc + PRE + 1; pend_bank = b; end
        if (v && op == 2'b00 && pend_at > cyc && b == pend_bank) pend_at = -1;
        ev[idx] = 1'b0;
        hh[idx] = dh;
        hl[idx] = dl;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
            chk(!arr_en, "R4", "arr_en idle", arr_en, 0);
        end
    endtask

    // tail: 0 none, 1 expect natural end, 2 burst stop then precharge
    task automatic burst(input logic wr, input logic b, input logic [7:0] s,
                         input logic [2:0] sel, input int beats, input int tail,
                         input string req);
        bit   full;
        int   lg;
        logic [7:0] lm;
        logic [7:0] col;
        logic dh;
        logic dl;
        full = (sel == 3'b111);
        lg   = (sel <= 3'd3) ? int'(sel) : 0;
        lm   = full ? 8'hFF : 8'((1 << lg) - 1);
        g_bl = sel;
        for (int k = 0; k < beats; k++) begin
            col = (s & ~lm) | ((s + 8'(k)) & lm);
            dh  = (k < 32) ? mh[k] : 1'b0;
            dl  = (k < 32) ? ml[k] : 1'b0;
            step(k == 0, wr ? 2'b10 : 2'b01, b, s, dh, dl, pat(b, col));
            chk(arr_en && arr_we == wr && arr_bank == b && arr_col == col,
                (k == 0) ? req : (full ? "R3" : "R2"), "access {en,we,bank,col}",
                {arr_en, arr_we, arr_bank, arr_col}, {1'b1, wr, b, col});
            if (wr) begin
                chk(arr_wstrb == ~{dh, dl}, "R8", "arr_wstrb", arr_wstrb, ~{dh, dl});
                chk(arr_wdata == pat(b, col), "R8", "arr_wdata", arr_wdata, pat(b, col));
            end else begin
                ev[(cur + (g_cl ? 3 : 2)) % HN] = 1'b1;
                ed[(cur + (g_cl ? 3 : 2)) % HN] = pat(b, col);
            end
        end
        if (tail == 1) begin
            step(1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
            chk(!arr_en, "R2", "arr_en after last beat", arr_en, 0);
        end else if (tail == 2) begin
            step(1'b1, 2'b11, b, 8'h00, 1'b0, 1'b0, 16'h0000);
            chk(!arr_en, "R4", "arr_en in stop cycle", arr_en, 0);
            step(1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
            chk(!arr_en, "R4", "arr_en after stop", arr_en, 0);
            step(1'b1, 2'b00, b, 8'h00, 1'b0, 1'b0, 16'h0000);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #750000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        logic [7:0] starts [0:3];
        for (int i = 0; i < HN; i++) begin ev[i] = 1'b0; hh[i] = 1'b0; hl[i] = 1'b0; end
        for (int i = 0; i < 32; i++) begin mh[i] = 1'b0; ml[i] = 1'b0; end
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0; cmd_col = 8'h00;
        cfg_bl = 3'b000; cfg_cl = 1'b0; dqm_hi = 1'b0; dqm_lo = 1'b0; dq_in = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        step(1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        chk(!arr_en && dq_oe == 2'b00 && !pre_late, "R1", "{arr_en,dq_oe,pre_late}",
            {arr_en, dq_oe, pre_late}, 0);
        idle(2);

        // R3: full-page fills, wrapping past the start, ended by a stop (R4)
        burst(1'b1, 1'b0, 8'd250, 3'b111, 260, 2, "R3");
        burst(1'b1, 1'b1, 8'd0,   3'b111, 256, 2, "R3");
        idle(2);

        // R2: fixed write bursts over lengths and starts
        starts[0] = 8'd0; starts[1] = 8'd5; starts[2] = 8'd10; starts[3] = 8'd255;
        for (int sel = 0; sel < 4; sel++)
            for (int si = 0; si < 4; si++)
                burst(1'b1, si[0], starts[si], 3'(sel), 1 << sel, 1, "R2");

        // R5: read bursts at both latencies
        starts[0] = 8'd3; starts[1] = 8'd6; starts[2] = 8'd129; starts[3] = 8'd254;
        for (int cl = 0; cl < 2; cl++) begin
            g_cl = cl[0];
            for (int sel = 0; sel < 4; sel++)
                for (int si = 0; si < 4; si++) begin
                    burst(1'b0, si[1], starts[si], 3'(sel), 1 << sel, 1, "R5");
                    idle(4);
                end
        end

        // R6/R7: full-page read with lane masks, stopped after 12 beats (R4)
        g_cl = 1'b1;
        data_req = "R7";
        mh[2] = 1'b1; mh[3] = 1'b1; mh[4] = 1'b1; ml[3] = 1'b1; ml[6] = 1'b1; ml[7] = 1'b1;
        burst(1'b0, 1'b0, 8'd100, 3'b111, 12, 2, "R6");
        idle(5);
        for (int i = 0; i < 32; i++) begin mh[i] = 1'b0; ml[i] = 1'b0; end

        // R6 at latency 2, upper lane only
        g_cl = 1'b0;
        mh[1] = 1'b1; mh[5] = 1'b1;
        burst(1'b0, 1'b1, 8'd60, 3'b011, 8, 1, "R6");
        idle(4);
        for (int i = 0; i < 32; i++) begin mh[i] = 1'b0; ml[i] = 1'b0; end
        data_req = "R5";

        // R8: write masks in the same cycle
        mh[1] = 1'b1; mh[3] = 1'b1; ml[0] = 1'b1; ml[3] = 1'b1;
        burst(1'b1, 1'b1, 8'd40, 3'b010, 4, 1, "R8");
        for (int i = 0; i < 32; i++) begin mh[i] = 1'b0; ml[i] = 1'b0; end
        burst(1'b0, 1'b1, 8'd40, 3'b010, 4, 1, "R8");
        idle(4);

        // R9: a read cuts a write burst short; then a write cuts a full-page read
        burst(1'b1, 1'b1, 8'd16, 3'b011, 3, 0, "R9");
        burst(1'b0, 1'b0, 8'd201, 3'b010, 4, 1, "R9");
        idle(4);
        burst(1'b0, 1'b1, 8'd250, 3'b111, 9, 0, "R9");
        burst(1'b1, 1'b0, 8'd77, 3'b001, 2, 1, "R9");
        idle(5);

        // R10: precharge exactly at the limit is on time
        step(1'b1, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(PRE - 1);
        step(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(4);
        // R10: precharge to the wrong bank does not clear the watch
        step(1'b1, 2'b11, 1'b1, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(4);
        step(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(PRE + 4);
        // R10: a second stop re-arms the window
        step(1'b1, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(8);
        step(1'b1, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0);
        idle(PRE + 3);

        finish_run();
    end

endmodule